// File: doc/BRIEF.md
# Channel Error Flag Bank with Clear Command

This block holds one sticky error flag for each of sixteen transfer channels. A channel raises its flag with a one-cycle pulse on its own set input. The flag then stays up until software clears it. The flags are read over a 32-bit register bus as a single status word, with bit n belonging to channel n.

Software clears flags by writing a command byte, not a bit mask. The byte carries three things. The first is an encoded channel index, which clears one flag. The second is a clear-everything bit. The third is a do-nothing bit, which lets a wide bus write pass over this byte without disturbing the flags. The command byte has no storage behind it and reads back as zero.

A new error always beats a clear that arrives in the same cycle, so no error report is lost.

Top module: `errflag_clear_bank`

## Requirements
- R1: After reset every flag is 0, so a status read (word address 0) returns 0, and `bus_rdata` is 0.
- R2: A 1 on `err_set_i[n]` sets flag n. Once set, the flag stays 1 until a command clears it.
- R3: A write to word address 1 with `bus_be[2]`=1 acts as a command. If bit 23 is 0 and bit 22 is 0, the write clears only the flag whose number is in bits 19:16, and leaves every other flag unchanged.
- R4: A command with bit 23=0 and bit 22=1 clears every flag, whatever bits 19:16 hold.
- R5: A command with bit 23=1 changes no flag, even when bit 22 is 1 or bits 19:16 hold an index.
- R6: Bits 21:20 of a command are reserved. They do not change which flags a command clears.
- R7: A write to word address 1 with `bus_be[2]`=0 changes no flag, whatever the other byte enables and data bits are.
- R8: If a set pulse and a clear command (single or all) hit the same channel in one cycle, that flag is 1 afterwards.
- R9: A read of word address 0 returns the flags in bits 15:0 and zeros above them. A read of word address 1 returns 0. A write to word address 0 changes no flag.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. It shows the flags as they were at the strobe edge. In a cycle that follows no read, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_set_i | input | 16 | Per-channel error set pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address (0 status, 1 command) |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
A set pulse or a command that enters at one clock edge changes the flags at that same edge. A read strobed in the following cycle is therefore the first to show the change. Read data is registered once, so it is due one cycle after its strobe. The bench drives on falling edges and keeps a queue of expected read words, each computed from a model of the flags as they stand at the strobe edge. Every falling edge it compares `bus_rdata` with the head of that queue, or with zero when the previous edge carried no read.

// File: rtl/errclr_pkg.sv
package errclr_pkg;
  localparam int BUS_W      = 32;
  localparam int BE_W       = BUS_W / 8;
  localparam int CMD_IDX_W  = 4;

  typedef struct packed {
    logic                 noop;
    logic                 all;
    logic [1:0]           rsvd;
    logic [CMD_IDX_W-1:0] idx;
  } cmd_t;
endpackage

// File: rtl/errclr_rst_sync.sv
module errclr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/errclr_cmd_decode.sv
module errclr_cmd_decode
  import errclr_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 4,
  parameter int CMD_ADDR = 1
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              lane_en,
  input  cmd_t              cmd,
  output logic [NUM_CH-1:0] clr_mask
);
  logic cmd_hit;
  logic do_all;
  logic do_one;
  logic unused_rsvd;

  always_comb begin
    cmd_hit = bus_wr && lane_en && (bus_addr == ADDR_W'(CMD_ADDR));
    do_all  = cmd_hit && !cmd.noop && cmd.all;
    do_one  = cmd_hit && !cmd.noop && !cmd.all;
  end

  assign unused_rsvd = ^cmd.rsvd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign clr_mask[i] = do_all || (do_one && (cmd.idx == CMD_IDX_W'(i)));
  end
endmodule

// File: rtl/errclr_flag_bank.sv
module errclr_flag_bank #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] flags_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
    logic en;
    logic d;
    logic q;

    always_comb begin
      en = set_i[i] || clr_i[i];
      d  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end

    assign flags_o[i] = q;
  end
endmodule

// File: rtl/errclr_read_port.sv
module errclr_read_port
  import errclr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NUM_CH-1:0] flags,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [BUS_W-1:0] rdata_d;
  logic [BUS_W-1:0] rdata_q;

  always_comb begin
    if (bus_rd && (bus_addr == ADDR_W'(STATUS_ADDR))) rdata_d = BUS_W'(flags);
    else                                               rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/errflag_clear_bank.sv
module errflag_clear_bank
  import errclr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int CMD_ADDR    = 1,
  parameter int CMD_LANE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] err_set_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int LANE_LSB = CMD_LANE * 8;

  logic              rst_n_sync;
  logic [NUM_CH-1:0] clr_mask;
  logic [NUM_CH-1:0] flags_q;
  cmd_t              cmd;
  logic              unused_bus_bits;

  assign cmd             = cmd_t'(bus_wdata[LANE_LSB +: 8]);
  assign unused_bus_bits = ^{bus_wdata, bus_be};

  errclr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  errclr_cmd_decode #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .CMD_ADDR (CMD_ADDR)
  ) u_dec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .lane_en  (bus_be[CMD_LANE]),
    .cmd      (cmd),
    .clr_mask (clr_mask)
  );

  errclr_flag_bank #(
    .NUM_CH (NUM_CH)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_i   (err_set_i),
    .clr_i   (clr_mask),
    .flags_o (flags_q)
  );

  errclr_read_port #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .flags     (flags_q),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: rtl/errclr_checker.sv
module errclr_checker
  import errclr_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int ADDR_W      = 4,
  parameter int STATUS_ADDR = 0,
  parameter int CMD_ADDR    = 1,
  parameter int CMD_LANE    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] err_set_i,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BE_W-1:0]   bus_be,
  input logic [NUM_CH-1:0] flags,
  input logic [BUS_W-1:0]  bus_rdata
);
  logic [7:0]        cbyte;
  logic              cmd_wr;
  logic              stat_rd;
  logic [NUM_CH-1:0] one_mask;
  logic              unused_chk;

  assign cbyte      = bus_wdata[CMD_LANE*8 +: 8];
  assign cmd_wr     = bus_wr && bus_be[CMD_LANE] && (bus_addr == ADDR_W'(CMD_ADDR));
  assign stat_rd    = bus_rd && (bus_addr == ADDR_W'(STATUS_ADDR));
  assign one_mask   = {{(NUM_CH-1){1'b0}}, 1'b1} << cbyte[3:0];
  assign unused_chk = ^{bus_wdata, bus_be, cbyte[5:4]};

  // R2 and R8: a set pulse always leaves its flag high
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set_i) |=> ((flags & $past(err_set_i)) == $past(err_set_i)));

  a_r3_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cbyte[7] && !cbyte[6]) |=>
      (flags == (($past(flags) & ~$past(one_mask)) | $past(err_set_i))));

  a_r4_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cbyte[7] && cbyte[6]) |=> (flags == $past(err_set_i)));

  a_r5_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cbyte[7]) |=> (flags == ($past(flags) | $past(err_set_i))));

  // R7 and R9: writes that are not commands clear nothing
  a_r7_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr) |=> (flags == ($past(flags) | $past(err_set_i))));

  a_r9_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata == BUS_W'($past(flags))));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd) |=> (bus_rdata == '0));
endmodule

bind errflag_clear_bank errclr_checker #(
  .NUM_CH      (NUM_CH),
  .ADDR_W      (ADDR_W),
  .STATUS_ADDR (STATUS_ADDR),
  .CMD_ADDR    (CMD_ADDR),
  .CMD_LANE    (CMD_LANE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .err_set_i (err_set_i),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be),
  .flags     (flags_q),
  .bus_rdata (bus_rdata)
);

// File: tb/errflag_clear_bank_bench.sv
`timescale 1ns/100ps
module errflag_clear_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] err_set_i = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;

  int          vectors = 0;
  int          fails = 0;
  bit          done = 1'b0;
  bit          mon_en = 1'b0;
  bit          had_rd = 1'b0;
  logic [15:0] model = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  errflag_clear_bank u_errflag_clear_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_set_i (err_set_i),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_rdata (bus_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle, queue expected read data, advance the model
  task automatic step(input logic [15:0] set, input logic wr, input logic [3:0] addr,
                      input logic [31:0] wd, input logic [3:0] be, input logic rd,
                      input string tag);
    logic [15:0] clr;
    logic [7:0]  c;
    err_set_i = set; bus_wr = wr; bus_addr = addr;
    bus_wdata = wd;  bus_be = be; bus_rd = rd;
    if (rd) begin
      exp_q.push_back(addr == 4'd0 ? {16'h0, model} : 32'h0);
      tag_q.push_back(tag);
    end
    clr = '0;
    c   = wd[23:16];
    if (wr && addr == 4'd1 && be[2] && !c[7]) begin
      if (c[6]) clr = '1;
      else      clr[c[3:0]] = 1'b1;
    end
    model = (model & ~clr) | set;
    @(negedge clk);
  endtask

  task automatic idle();
    step('0, 1'b0, 4'd0, 32'h0, 4'h0, 1'b0, "R10");
  endtask

  task automatic rd_status(input string tag);
    step('0, 1'b0, 4'd0, 32'h0, 4'h0, 1'b1, tag);
  endtask

  task automatic cmd(input logic [7:0] b, input string tag);
    step('0, 1'b1, 4'd1, {8'h00, b, 16'h0000}, 4'b0100, 1'b0, tag);
  endtask

  // Monitor
  always @(posedge clk) had_rd <= bus_rd;

  always @(negedge clk) begin
    if (mon_en) begin
      if (had_rd) check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      else        check("R10", bus_rdata, 32'h0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: rdata=%h expected=end of run", bus_rdata);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;

    rd_status("R1");
    idle();

    // R2: pulses set flags that stay
    step(16'h8008, 1'b0, 4'd0, 32'h0, 4'h0, 1'b0, "R2");
    idle(); idle();
    rd_status("R2");
    step(16'h0001, 1'b0, 4'd0, 32'h0, 4'h0, 1'b1, "R2");
    rd_status("R2");

    // R3: single clear
    cmd(8'h03, "R3");
    rd_status("R3");
    cmd(8'h0F, "R3");
    rd_status("R3");

    // R3: walk every index from a full bank
    step(16'hFFFF, 1'b0, 4'd0, 32'h0, 4'h0, 1'b0, "R3");
    for (int i = 0; i < 16; i++) begin
      cmd(8'(i), "R3");
      rd_status("R3");
    end

    // R4: clear-all ignores index
    step(16'hA5C3, 1'b0, 4'd0, 32'h0, 4'h0, 1'b0, "R4");
    rd_status("R4");
    cmd(8'h45, "R4");
    rd_status("R4");

    // R5: no-op wins over clear-all and index
    step(16'h1234, 1'b0, 4'd0, 32'h0, 4'h0, 1'b0, "R5");
    cmd(8'hC4, "R5");
    rd_status("R5");
    cmd(8'h82, "R5");
    rd_status("R5");

    // R6: reserved bits do not widen or block a clear
    cmd(8'h32, "R6");
    rd_status("R6");
    cmd(8'h34, "R6");
    rd_status("R6");

    // R7: lane 2 disabled
    step('0, 1'b1, 4'd1, 32'h0040_0000, 4'b1011, 1'b0, "R7");
    rd_status("R7");
    step('0, 1'b1, 4'd1, 32'hFF4C_FFFF, 4'b0000, 1'b0, "R7");
    rd_status("R7");

    // R8: set beats a single clear and a clear-all
    step(16'h0010, 1'b1, 4'd1, 32'h0004_0000, 4'b0100, 1'b0, "R8");
    rd_status("R8");
    step(16'h0080, 1'b1, 4'd1, 32'h0040_0000, 4'b0100, 1'b0, "R8");
    rd_status("R8");

    // R9: command reads zero, status writes ignored
    step('0, 1'b0, 4'd1, 32'h0, 4'h0, 1'b1, "R9");
    step('0, 1'b1, 4'd0, 32'h0000_0000, 4'b1111, 1'b0, "R9");
    step('0, 1'b1, 4'd0, 32'h0040_FFFF, 4'b1111, 1'b0, "R9");
    rd_status("R9");

    // R10: back-to-back reads, each shows state at its own edge
    step(16'h0002, 1'b0, 4'd0, 32'h0, 4'h0, 1'b1, "R10");
    rd_status("R10");
    idle(); idle();

    mon_en = 1'b0;
    done   = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule